// File: doc/BRIEF.md
# Core Idle-State Coordination Controller

This block follows the idle depth chosen by each hardware thread of a core and derives the idle state of the core they share. A thread in the active state can ask to go idle. Each request carries a kind (halt, monitor-wait or I/O-based) and a target depth. Each thread keeps its own state and also remembers whether it got there through a monitor-wait. That record decides whether a hit on the monitored address may wake it. An interrupt always wakes the thread. The core state is the shallowest state held by any thread. When the enhanced option is set, a core C1 is reported as the enhanced C1E code.

Coherence snoops arrive on a valid/ready pair. In C0, C1 or C1E a snoop is served straight away. In C3 or C6 it first waits for a short wake handshake. In both cases the reported core state does not change. The upstream agent must hold `snoop_valid` until it sees `snoop_ready` high at a rising edge. `snoop_ready` stays low from the accepting edge until the end of the cycle in which `snoop_served` pulses, so the block serves only one snoop at a time.

Top module: `idle_coord_top`

## Requirements
- R1: States are 3-bit codes: C0=0, C1=1, C1E=2, C3=3, C6=4. Request kinds are 2-bit codes: halt=0, monitor-wait=1, I/O=2, with 3 reserved. A thread in C0 that takes a halt request, or a monitor-wait request with depth code 1, shows C1 on its state output after the next clock edge.
- R2: A monitor-wait request with depth 3 or 4 moves the thread to C3 or C6. An I/O request with depth 3 or 4 does the same. Any other depth for these two kinds, and any request of kind 3, leaves the thread in C0.
- R3: The core state equals the numerically smallest thread state, so it is C0 whenever any thread is in C0. The core state is registered and changes one clock edge after the thread state it follows.
- R4: While `c1e_en` is high, a core C1 is reported as code 2 (C1E), one edge after the change in `c1e_en` or in the thread states.
- R5: An interrupt to a thread that is not in C0 returns that thread to C0 at the next edge.
- R6: A monitored-address hit wakes a thread to C0 only if the thread entered its state through monitor-wait. A thread that entered through a halt or an I/O request keeps its state.
- R7: A snoop accepted while the core is in C0, C1 or C1E raises `snoop_served` one edge after the accepting edge. The core state does not change.
- R8: While `rst_n` is low, all thread states and the core state read C0 and `snoop_served` is low. The record of how each thread entered its state is cleared.
- R9: A request to a thread that is not in C0 is ignored. A request and an interrupt for the same thread in the same cycle resolve to C0, so the request has no effect.
- R10: A snoop accepted while the core is in C3 or C6 raises `snoop_served` three edges after the accepting edge: a two-cycle wake handshake, then the service cycle. The core state does not change meanwhile.
- R11: `snoop_served` is high for a single cycle. `snoop_ready` is low from the accepting edge until that pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c1e_en | input | 1 | Report core C1 as C1E |
| req_valid | input | NUM_THREADS | Idle-entry request, one bit per thread |
| req_kind | input | 2*NUM_THREADS | Request kind per thread (halt/monitor-wait/I-O) |
| req_depth | input | 3*NUM_THREADS | Target depth per thread, as a state code |
| irq | input | NUM_THREADS | Interrupt per thread |
| mon_hit | input | NUM_THREADS | Monitored-address write hit per thread |
| snoop_valid | input | 1 | Snoop request valid |
| snoop_ready | output | 1 | Snoop can be accepted |
| snoop_served | output | 1 | One-cycle pulse when the snoop has been serviced |
| thr_state | output | 3*NUM_THREADS | Current state code per thread |
| core_state | output | 3 | Resolved core state code |

## Verification
The bench builds the block with its default parameters: two threads and a two-cycle snoop wake handshake. With two threads, the minimum rule can be tested on mixed depths such as C6 against C3, and on one active thread against an idle one. The short handshake makes the deep-snoop latency of three edges, and the shallow latency of one edge, short enough to check edge by edge. With this build the bench can also exercise halt entries that ignore the monitor, a same-cycle interrupt and request, and a reset applied from a deep state.

// File: rtl/idle_pkg.sv
package idle_pkg;
  localparam int STW = 3;
  localparam int KW  = 2;

  typedef enum logic [STW-1:0] {
    ST_C0  = 3'd0,
    ST_C1  = 3'd1,
    ST_C1E = 3'd2,
    ST_C3  = 3'd3,
    ST_C6  = 3'd4
  } cstate_e;

  typedef enum logic [KW-1:0] {
    K_HALT  = 2'd0,
    K_MWAIT = 2'd1,
    K_IO    = 2'd2,
    K_RSVD  = 2'd3
  } kind_e;
endpackage

// File: rtl/idle_thread_fsm.sv
module idle_thread_fsm
  import idle_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [KW-1:0]        req_kind,
  input  logic [STW-1:0]       req_depth,
  input  logic                 irq,
  input  logic                 mon_hit,
  output logic [STW-1:0]       state_o
);
  cstate_e state_q;
  logic    via_mon_q;
  logic    tgt_ok;
  cstate_e tgt;
  logic    tgt_mon;
  logic    wake;

  // decode the requested target
  always_comb begin
    tgt_ok  = 1'b0;
    tgt     = ST_C0;
    tgt_mon = 1'b0;
    unique case (kind_e'(req_kind))
      K_HALT: begin
        tgt_ok = 1'b1;
        tgt    = ST_C1;
      end
      K_MWAIT: begin
        tgt_mon = 1'b1;
        if (req_depth == ST_C1 || req_depth == ST_C3 || req_depth == ST_C6) begin
          tgt_ok = 1'b1;
          tgt    = cstate_e'(req_depth);
        end
      end
      K_IO: begin
        if (req_depth == ST_C3 || req_depth == ST_C6) begin
          tgt_ok = 1'b1;
          tgt    = cstate_e'(req_depth);
        end
      end
      default: tgt_ok = 1'b0;
    endcase
  end

  assign wake = irq | (mon_hit & via_mon_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_C0;
      via_mon_q <= 1'b0;
    end else if (wake) begin
      state_q   <= ST_C0;
      via_mon_q <= 1'b0;
    end else if (state_q == ST_C0 && req_valid && tgt_ok) begin
      state_q   <= tgt;
      via_mon_q <= tgt_mon;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/idle_core_resolve.sv
module idle_core_resolve
  import idle_pkg::*;
#(
  parameter int NT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 c1e_en,
  input  logic [STW*NT-1:0]    thr_flat,
  output logic [STW-1:0]       core_o
);
  logic [STW-1:0] shallow;
  cstate_e        res;
  cstate_e        core_q;

  always_comb begin
    shallow = ST_C6;
    for (int i = 0; i < NT; i++) begin
      if (thr_flat[STW*i +: STW] < shallow) shallow = thr_flat[STW*i +: STW];
    end
    res = cstate_e'(shallow);
    if (res == ST_C1 && c1e_en) res = ST_C1E;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) core_q <= ST_C0;
    else        core_q <= res;
  end

  assign core_o = core_q;
endmodule

// File: rtl/idle_snoop_unit.sv
module idle_snoop_unit
  import idle_pkg::*;
#(
  parameter int WAKE_CYC = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [STW-1:0] core_state,
  input  logic           snoop_valid,
  output logic           snoop_ready,
  output logic           snoop_served
);
  localparam int CW = $clog2(WAKE_CYC + 2);
  localparam logic [CW-1:0] DEEP_LAT    = CW'(WAKE_CYC + 1);
  localparam logic [CW-1:0] SHALLOW_LAT = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          served_q;
  logic          accept;
  logic          deep;

  assign snoop_ready = (cnt_q == '0) && !served_q;
  assign accept      = snoop_valid && snoop_ready;
  assign deep        = (core_state == ST_C3) || (core_state == ST_C6);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      served_q <= 1'b0;
    end else begin
      served_q <= (cnt_q == CW'(1));
      if (accept)             cnt_q <= deep ? DEEP_LAT : SHALLOW_LAT;
      else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
    end
  end

  assign snoop_served = served_q;
endmodule

// File: rtl/idle_coord_top.sv
module idle_coord_top
  import idle_pkg::*;
#(
  parameter int NUM_THREADS       = 2,
  parameter int SNOOP_WAKE_CYCLES = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       c1e_en,
  input  logic [NUM_THREADS-1:0]     req_valid,
  input  logic [2*NUM_THREADS-1:0]   req_kind,
  input  logic [3*NUM_THREADS-1:0]   req_depth,
  input  logic [NUM_THREADS-1:0]     irq,
  input  logic [NUM_THREADS-1:0]     mon_hit,
  input  logic                       snoop_valid,
  output logic                       snoop_ready,
  output logic                       snoop_served,
  output logic [3*NUM_THREADS-1:0]   thr_state,
  output logic [2:0]                 core_state
);
  logic [STW*NUM_THREADS-1:0] thr_flat;

  for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
    idle_thread_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid[g]),
      .req_kind  (req_kind[KW*g +: KW]),
      .req_depth (req_depth[STW*g +: STW]),
      .irq       (irq[g]),
      .mon_hit   (mon_hit[g]),
      .state_o   (thr_flat[STW*g +: STW])
    );
  end

  idle_core_resolve #(.NT(NUM_THREADS)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .c1e_en   (c1e_en),
    .thr_flat (thr_flat),
    .core_o   (core_state)
  );

  idle_snoop_unit #(.WAKE_CYC(SNOOP_WAKE_CYCLES)) u_snp (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_state   (core_state),
    .snoop_valid  (snoop_valid),
    .snoop_ready  (snoop_ready),
    .snoop_served (snoop_served)
  );

  assign thr_state = thr_flat;
endmodule

// File: rtl/idle_coord_chk.sv
module idle_coord_chk #(
  parameter int NT = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            c1e_en,
  input logic [NT-1:0]   req_valid,
  input logic [NT-1:0]   irq,
  input logic            snoop_valid,
  input logic            snoop_ready,
  input logic            snoop_served,
  input logic [3*NT-1:0] thr_state,
  input logic [2:0]      core_state
);
  logic any_c0;
  always_comb begin
    any_c0 = 1'b0;
    for (int i = 0; i < NT; i++) if (thr_state[3*i +: 3] == 3'd0) any_c0 = 1'b1;
  end

  for (genvar g = 0; g < NT; g++) begin : g_t
    AST_THR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_state[3*g +: 3] == 3'd0 || thr_state[3*g +: 3] == 3'd1 ||
       thr_state[3*g +: 3] == 3'd3 || thr_state[3*g +: 3] == 3'd4)); // R1
    AST_IRQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |=> thr_state[3*g +: 3] == 3'd0); // R5
    AST_NO_REQ_STAY: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_state[3*g +: 3] == 3'd0 && !req_valid[g]) |=> thr_state[3*g +: 3] == 3'd0); // R9
  end

  AST_CORE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    any_c0 |=> core_state == 3'd0); // R3
  AST_C1E_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    core_state == 3'd2 |-> $past(c1e_en)); // R4
  AST_SERVED_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_served |=> !snoop_served); // R11
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_valid && snoop_ready) |=> !snoop_ready); // R11
endmodule

bind idle_coord_top idle_coord_chk #(.NT(NUM_THREADS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .c1e_en       (c1e_en),
  .req_valid    (req_valid),
  .irq          (irq),
  .snoop_valid  (snoop_valid),
  .snoop_ready  (snoop_ready),
  .snoop_served (snoop_served),
  .thr_state    (thr_state),
  .core_state   (core_state)
);

// File: tb/tb_idle_coord_top.sv
`timescale 1ns/1ps
module tb_idle_coord_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       c1e_en = 1'b0;
  logic [1:0] req_valid = '0;
  logic [3:0] req_kind = '0;
  logic [5:0] req_depth = '0;
  logic [1:0] irq = '0;
  logic [1:0] mon_hit = '0;
  logic       snoop_valid = 1'b0;
  logic       snoop_ready, snoop_served;
  logic [5:0] thr_state;
  logic [2:0] core_state;
  int vectors = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  idle_coord_top dut (.*);

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int th(int t);
    return int'(thr_state[3*t +: 3]);
  endfunction

  task automatic enter(int t, logic [1:0] k, logic [2:0] d, logic with_irq = 1'b0);
    @(negedge clk);
    req_valid[t] = 1'b1; req_kind[2*t +: 2] = k; req_depth[3*t +: 3] = d;
    irq[t] = with_irq;
    @(negedge clk);
    req_valid[t] = 1'b0; irq[t] = 1'b0;
  endtask

  task automatic pulse_irq(int t);
    @(negedge clk); irq[t] = 1'b1;
    @(negedge clk); irq[t] = 1'b0;
  endtask

  task automatic pulse_mon(int t);
    @(negedge clk); mon_hit[t] = 1'b1;
    @(negedge clk); mon_hit[t] = 1'b0;
  endtask

  task automatic snoop(string tag, int lat, int exp_core);
    @(negedge clk);
    chk({tag, " ready before"}, snoop_ready, 1);
    snoop_valid = 1'b1;
    @(negedge clk);
    snoop_valid = 1'b0;
    chk("R11 ready low after accept", snoop_ready, 0);
    for (int j = 1; j <= lat + 1; j++) begin
      if (j > 1) @(negedge clk);
      chk({tag, " served timing"}, snoop_served, (j == lat + 1) ? 1 : 0);
      chk({tag, " core unchanged"}, core_state, exp_core);
    end
    @(negedge clk);
    chk("R11 served single cycle", snoop_served, 0);
  endtask

  task automatic t_reset();
    chk("R8 thr0 reset", th(0), 0);
    chk("R8 thr1 reset", th(1), 0);
    chk("R8 core reset", core_state, 0);
    chk("R8 served reset", snoop_served, 0);
  endtask

  task automatic t_c1();
    enter(0, 2'd0, 3'd0);
    chk("R1 halt to C1", th(0), 1);
    chk("R3 core active thread1", core_state, 0);
    enter(1, 2'd1, 3'd1);
    chk("R1 mwait C1", th(1), 1);
    chk("R3 core lags one edge", core_state, 0);
    @(negedge clk);
    chk("R3 core C1", core_state, 1);
  endtask

  task automatic t_c1e();
    @(negedge clk); c1e_en = 1'b1;
    @(negedge clk);
    chk("R4 core C1E", core_state, 2);
    snoop("R7 C1E", 1, 2);
    @(negedge clk); c1e_en = 1'b0;
    @(negedge clk);
    chk("R4 core back to C1", core_state, 1);
  endtask

  task automatic t_monitor();
    pulse_mon(0);
    chk("R6 halt ignores monitor", th(0), 1);
    pulse_mon(1);
    chk("R6 mwait woken by monitor", th(1), 0);
    @(negedge clk);
    chk("R3 core C0 after wake", core_state, 0);
    pulse_irq(0);
    chk("R5 irq wakes thr0", th(0), 0);
  endtask

  task automatic t_deep();
    enter(0, 2'd1, 3'd4);
    chk("R2 mwait C6", th(0), 4);
    enter(1, 2'd2, 3'd3);
    chk("R2 io C3", th(1), 3);
    @(negedge clk);
    chk("R3 core min C3", core_state, 3);
    enter(1, 2'd1, 3'd1);
    chk("R9 request ignored when idle", th(1), 3);
    pulse_mon(1);
    chk("R6 io entry ignores monitor", th(1), 3);
    snoop("R10 deep", 3, 3);
    pulse_mon(0);
    chk("R6 mwait C6 woken", th(0), 0);
  endtask

  task automatic t_priority();
    enter(0, 2'd0, 3'd0, 1'b1);
    chk("R9 irq beats request", th(0), 0);
    enter(0, 2'd1, 3'd2);
    chk("R2 bad mwait depth", th(0), 0);
    enter(0, 2'd2, 3'd1);
    chk("R2 bad io depth", th(0), 0);
    enter(0, 2'd3, 3'd3);
    chk("R2 reserved kind", th(0), 0);
    @(negedge clk);
    chk("R3 core C0", core_state, 0);
    snoop("R7 C0", 1, 0);
  endtask

  task automatic t_midreset();
    enter(0, 2'd1, 3'd4);
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R8 thr0 cleared", th(0), 0);
    chk("R8 thr1 cleared", th(1), 0);
    chk("R8 core cleared", core_state, 0);
    @(negedge clk); rst_n = 1'b1;
    enter(0, 2'd0, 3'd0);
    pulse_mon(0);
    chk("R8 entry record cleared", th(0), 1);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_c1();
    t_c1e();
    t_monitor();
    t_deep();
    t_priority();
    t_midreset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule